// File: doc/BRIEF.md
# Microwire Serial EEPROM Device Model

This block is a synthesizable model of a small serial EEPROM holding 16-bit words, meant to sit across from a host controller in an FPGA prototype or a simulation of a larger chip. The host raises the select line and shifts an instruction in on the serial input, one bit per rising clock edge. An instruction is a single 1 bit, then a two-bit operation code, then an address that is 6 or 8 bits wide depending on the device size. Write-style instructions then carry a 16-bit data word. Reads answer on the serial output with a leading zero followed by the stored word.

All commands that change the array are blocked until the host issues the unlock sub-command. They stay blocked again after the lock sub-command or a reset. A program operation keeps the model busy for a parameterised number of clocks. A bulk operation takes at least one clock per word, because the array is written one word per cycle. While busy, a host that drops select and raises it again sees 0 on the serial output, and sees 1 once the model is ready. Start bits arriving while busy are not taken. Dropping select at any point abandons a half-shifted instruction.

The array is a plain register file with one synchronous read port and one write port, so an FPGA flow can map it to block RAM. Its contents are not cleared by reset.

Top module: `mw_eeprom`

## Requirements
- R1: While select is high and the model is idle and ready, 0 bits on the serial input are skipped; the first 1 bit starts an instruction, and the next two bits are the operation code, first bit most significant: 10 read, 01 write, 11 erase, 00 extended.
- R2: For a read, the rising edge that takes the last address bit drives 0 on the serial output. The next 16 rising edges each drive one bit of the addressed word, most significant bit first.
- R3: A write takes 16 data bits after the address, most significant first. When it is accepted, it stores that word at the address.
- R4: An accepted erase sets the addressed word to all ones (0xFFFF).
- R5: For the extended code, the top two address bits pick the sub-command: 11 unlock, 00 lock, 10 erase all, 01 write all. The lower address bits have no effect.
- R6: Write, erase, erase-all and write-all leave the array unchanged unless unlock was issued after the most recent lock or reset. Reset clears the unlock state but not the array.
- R7: An accepted erase-all sets every word to 0xFFFF. An accepted write-all, with 16 data bits after the address, sets every word to that value.
- R8: Lowering select before an instruction is complete discards it with no effect on the array, and the next instruction is decoded from its start bit.
- R9: After an accepted program instruction ends on rising edge E, the host lowers select for one clock and then holds it high. Following edge E+n, the serial output reads 0 while n is below BUSY_CYCLES+2 (single-word) or max(BUSY_CYCLES, 2^ADDR_W)+2 (bulk), and reads 1 from that edge on.
- R10: Start bits that arrive while the model is busy are ignored, so an instruction shifted in during that time has no effect.
- R11: During and right after reset the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; bits are sampled and launched on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Select; high frames an instruction, low aborts it |
| sdi | input | 1 | Serial instruction, address and data input |
| sdo | output | 1 | Serial output: read data, or ready/busy status |

## Verification
The hardest situation to reach from the ports is an instruction that arrives in the narrow window while a program cycle is still running. The bench completes a write, lowers select for exactly one clock, and then shifts a full erase of the same word while the busy count is still running. After the model goes idle, it reads the word back, and the word must still hold the written value. The exact busy-to-ready edge is pinned down by counting clocks from the final data edge of each single-word and bulk command. The partially shifted instructions used for the abort checks are cut in the middle of the address and in the middle of the data.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  typedef enum logic [1:0] {
    SUB_LOCK   = 2'b00,
    SUB_FILL   = 2'b01,
    SUB_WIPE   = 2'b10,
    SUB_UNLOCK = 2'b11
  } mw_sub_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OP, S_ADDR, S_DATA, S_READ, S_DONE
  } mw_state_e;
endpackage

// File: rtl/mw_store_array.sv
module mw_store_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              req_i,
  input  logic              bulk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sweep_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] fill_q;
  logic [ADDR_W-1:0] sw_addr_q;
  logic              sweep_q;
  logic              we;
  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] wd;

  always_comb begin
    we = sweep_q | (req_i & ~bulk_i);
    wa = sweep_q ? sw_addr_q : addr_i;
    wd = sweep_q ? fill_q : data_i;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) rd_q <= mem[rd_addr_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_q   <= 1'b0;
      sw_addr_q <= '0;
      fill_q    <= '0;
    end else if (sweep_q) begin
      if (sw_addr_q == LAST) sweep_q <= 1'b0;
      else sw_addr_q <= sw_addr_q + ADDR_W'(1);
    end else if (req_i && bulk_i) begin
      sweep_q   <= 1'b1;
      sw_addr_q <= '0;
      fill_q    <= data_i;
    end
  end

  assign rd_data_o = rd_q;
  assign sweep_o   = sweep_q;

  // R7: a bulk sweep ends only after the last word was written
  a_r7_sweep_covers_all: assert property (@(posedge clk) disable iff (rst)
    $fell(sweep_q) |-> ($past(sw_addr_q) == LAST));
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
  parameter int BUSY_CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic hold_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (start_i) cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0) | hold_i;

  // R9: a program request always makes the model busy on the next cycle
  a_r9_start_makes_busy: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);
endmodule

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              di_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              prog_req_o,
  output logic              prog_bulk_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              dout_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(DATA_W);
  localparam logic [DATA_W-1:0] ONES     = '1;

  mw_state_e         state_q;
  mw_op_e            op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-2:0] data_q;
  logic [DATA_W-2:0] rd_sh_q;
  logic              en_q;
  logic              status_q;
  logic              dout_q;
  logic              req_q;
  logic              bulk_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pdata_q;

  logic [ADDR_W-1:0] addr_nx;
  logic [DATA_W-1:0] data_nx;
  logic              busy_any;
  logic              addr_done;
  logic              data_done;
  mw_sub_e           sub;

  always_comb begin
    addr_nx   = {addr_q[ADDR_W-2:0], di_i};
    data_nx   = {data_q, di_i};
    busy_any  = busy_i | req_q;
    addr_done = (state_q == S_ADDR) && (cnt_q == ADDR_LAST);
    data_done = (state_q == S_DATA) && (cnt_q == DATA_LAST);
    sub       = mw_sub_e'(addr_nx[ADDR_W-1 -: 2]);
    rd_en_o   = cs_i && addr_done && (op_q == OP_READ);
    rd_addr_o = addr_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      op_q     <= OP_EXT;
      cnt_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      rd_sh_q  <= '0;
      en_q     <= 1'b0;
      status_q <= 1'b0;
      dout_q   <= 1'b0;
      req_q    <= 1'b0;
      bulk_q   <= 1'b0;
      paddr_q  <= '0;
      pdata_q  <= '0;
    end else begin
      req_q <= 1'b0;
      if (!cs_i) begin
        state_q <= S_IDLE;
        cnt_q   <= '0;
        dout_q  <= 1'b0;
      end else begin
        case (state_q)
          S_IDLE: begin
            dout_q <= status_q & ~busy_any;
            if (!busy_any && di_i) begin
              state_q  <= S_OP;
              cnt_q    <= '0;
              status_q <= 1'b0;
              dout_q   <= 1'b0;
            end
          end
          S_OP: begin
            dout_q <= 1'b0;
            op_q   <= mw_op_e'({op_q[0], di_i});
            if (cnt_q == CNT_W'(1)) begin
              state_q <= S_ADDR;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          S_ADDR: begin
            dout_q <= 1'b0;
            addr_q <= addr_nx;
            cnt_q  <= cnt_q + CNT_W'(1);
            if (addr_done) begin
              cnt_q   <= '0;
              state_q <= S_DONE;
              case (op_q)
                OP_READ:  state_q <= S_READ;
                OP_WRITE: state_q <= S_DATA;
                OP_ERASE: begin
                  if (en_q) begin
                    req_q    <= 1'b1;
                    bulk_q   <= 1'b0;
                    paddr_q  <= addr_nx;
                    pdata_q  <= ONES;
                    status_q <= 1'b1;
                  end
                end
                default: begin
                  case (sub)
                    SUB_UNLOCK: en_q <= 1'b1;
                    SUB_LOCK:   en_q <= 1'b0;
                    SUB_FILL:   state_q <= S_DATA;
                    default: begin
                      if (en_q) begin
                        req_q    <= 1'b1;
                        bulk_q   <= 1'b1;
                        pdata_q  <= ONES;
                        status_q <= 1'b1;
                      end
                    end
                  endcase
                end
              endcase
            end
          end
          S_DATA: begin
            dout_q <= 1'b0;
            data_q <= data_nx[DATA_W-2:0];
            cnt_q  <= cnt_q + CNT_W'(1);
            if (data_done) begin
              state_q <= S_DONE;
              if (en_q) begin
                req_q    <= 1'b1;
                bulk_q   <= (op_q == OP_EXT);
                paddr_q  <= addr_q;
                pdata_q  <= data_nx;
                status_q <= 1'b1;
              end
            end
          end
          S_READ: begin
            if (cnt_q == '0) begin
              dout_q  <= rd_data_i[DATA_W-1];
              rd_sh_q <= rd_data_i[DATA_W-2:0];
              cnt_q   <= CNT_W'(1);
            end else if (cnt_q == DATA_END) begin
              dout_q  <= 1'b0;
              state_q <= S_DONE;
            end else begin
              dout_q  <= rd_sh_q[DATA_W-2];
              rd_sh_q <= {rd_sh_q[DATA_W-3:0], 1'b0};
              cnt_q   <= cnt_q + CNT_W'(1);
            end
          end
          default: dout_q <= 1'b0;
        endcase
      end
    end
  end

  assign prog_req_o  = req_q;
  assign prog_bulk_o = bulk_q;
  assign prog_addr_o = paddr_q;
  assign prog_data_o = pdata_q;
  assign dout_o      = dout_q;

  // R8: a low select always returns the decoder to waiting for a start bit
  a_r8_abort_to_idle: assert property (@(posedge clk) disable iff (rst)
    !cs_i |=> (state_q == S_IDLE));
  // R6: no program request leaves while programming is locked
  a_r6_locked_no_program: assert property (@(posedge clk) disable iff (rst)
    req_q |-> en_q);
  // R10: no instruction begins while busy
  a_r10_busy_blocks_start: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && busy_any) |=> (state_q == S_IDLE));
  // R9: status reads low while busy
  a_r9_status_low_busy: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && cs_i && busy_any) |=> !dout_q);
  // R2: the read word is preceded by a zero
  a_r2_leading_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |=> !dout_q);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic sdi,
  output logic sdo
);
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              prog_req;
  logic              prog_bulk;
  logic [ADDR_W-1:0] prog_addr;
  logic [DATA_W-1:0] prog_data;
  logic              sweeping;
  logic              busy;

  mw_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec (
    .clk(clk), .rst(rst), .cs_i(sel), .di_i(sdi), .busy_i(busy),
    .rd_data_i(rd_data), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .prog_req_o(prog_req), .prog_bulk_o(prog_bulk),
    .prog_addr_o(prog_addr), .prog_data_o(prog_data), .dout_o(sdo)
  );

  mw_store_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_arr (
    .clk(clk), .rst(rst), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .req_i(prog_req), .bulk_i(prog_bulk),
    .addr_i(prog_addr), .data_i(prog_data), .sweep_o(sweeping)
  );

  mw_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_busy (
    .clk(clk), .rst(rst), .start_i(prog_req), .hold_i(sweeping),
    .busy_o(busy)
  );
endmodule

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int BUSY  = 24;
  localparam int DEPTH = 1 << AW;
  localparam int N_ONE  = BUSY + 2;
  localparam int N_BULK = ((BUSY > DEPTH) ? BUSY : DEPTH) + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BUSY)) i_mw_eeprom (
    .clk(clk), .rst(rst), .sel(sel), .sdi(sdi), .sdo(sdo)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic c, input logic d, output logic o);
    sel = c; sdi = d;
    @(posedge clk);
    @(negedge clk);
    o = sdo;
  endtask

  task automatic idle(input int n);
    logic o;
    repeat (n) tick(1'b0, 1'b0, o);
  endtask

  task automatic head(input logic [1:0] op, input logic [AW-1:0] a, output logic last);
    logic o;
    tick(1'b1, 1'b1, o);
    tick(1'b1, op[1], o);
    tick(1'b1, op[0], o);
    for (int i = AW - 1; i >= 0; i--) tick(1'b1, a[i], o);
    last = o;
  endtask

  task automatic data_bits(input logic [DW-1:0] d);
    logic o;
    for (int i = DW - 1; i >= 0; i--) tick(1'b1, d[i], o);
  endtask

  task automatic poll(output int n);
    logic o;
    tick(1'b0, 1'b0, o);
    n = 1;
    do begin
      n++;
      tick(1'b1, 1'b0, o);
    end while (!o && n < 400);
    tick(1'b0, 1'b0, o);
  endtask

  task automatic read_expect(input string tag, input int lead,
                             input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic o, dmy;
    logic [DW-1:0] w;
    repeat (lead) tick(1'b1, 1'b0, o);
    head(2'b10, a, dmy);
    w = '0;
    for (int i = 0; i < DW; i++) begin
      tick(1'b1, 1'b0, o);
      w = {w[DW-2:0], o};
    end
    idle(2);
    chk({tag, " R2 dummy zero"}, {31'b0, dmy}, 32'h0);
    chk(tag, {16'b0, w}, {16'b0, exp});
  endtask

  task automatic ext_cmd(input logic [1:0] sub, input logic [AW-3:0] dc);
    logic o;
    head(2'b00, {sub, dc}, o);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R11 sdo in reset", {31'b0, sdo}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 sdo after reset", {31'b0, sdo}, 32'h0);
  endtask

  task automatic t_erase_all;
    int n;
    ext_cmd(2'b11, 4'b0000); idle(1);
    ext_cmd(2'b10, 4'b0000);
    poll(n);
    chk("R9 R7 erase-all ready edge", n, N_BULK);
    read_expect("R7 erase-all word 0", 0, 6'd0, 16'hFFFF);
    read_expect("R7 erase-all word 20", 0, 6'd20, 16'hFFFF);
    read_expect("R7 erase-all word 63", 0, 6'd63, 16'hFFFF);
  endtask

  task automatic t_write_read;
    int n;
    logic o;
    head(2'b01, 6'd5, o); data_bits(16'h1234);
    poll(n);
    chk("R9 write ready edge", n, N_ONE);
    read_expect("R3 write word 5", 0, 6'd5, 16'h1234);
    read_expect("R3 neighbour word 6", 0, 6'd6, 16'hFFFF);
    read_expect("R1 leading zeros skipped", 4, 6'd5, 16'h1234);
    head(2'b01, 6'd63, o); data_bits(16'hA5C3);
    poll(n);
    read_expect("R2 R3 bit order word 63", 0, 6'd63, 16'hA5C3);
  endtask

  task automatic t_erase;
    int n;
    logic o;
    head(2'b11, 6'd5, o);
    poll(n);
    chk("R9 erase ready edge", n, N_ONE);
    read_expect("R4 erased word 5", 0, 6'd5, 16'hFFFF);
    read_expect("R4 word 63 untouched", 0, 6'd63, 16'hA5C3);
  endtask

  task automatic t_write_all;
    int n;
    ext_cmd(2'b01, 4'b1001); data_bits(16'h0F0F);
    poll(n);
    chk("R9 R7 write-all ready edge", n, N_BULK);
    read_expect("R7 write-all word 0", 0, 6'd0, 16'h0F0F);
    read_expect("R7 write-all word 37", 0, 6'd37, 16'h0F0F);
    read_expect("R7 write-all word 63", 0, 6'd63, 16'h0F0F);
  endtask

  task automatic t_lock;
    int n;
    logic o;
    ext_cmd(2'b00, 4'b0110); idle(1);
    head(2'b01, 6'd2, o); data_bits(16'h1111); idle(30);
    read_expect("R6 R5 locked write ignored", 0, 6'd2, 16'h0F0F);
    head(2'b11, 6'd2, o); idle(30);
    ext_cmd(2'b10, 4'b0000); idle(80);
    read_expect("R6 locked erases ignored", 0, 6'd2, 16'h0F0F);
    ext_cmd(2'b11, 4'b0101); idle(1);
    head(2'b01, 6'd2, o); data_bits(16'h2222);
    poll(n);
    chk("R5 unlock with don't-care bits, ready edge", n, N_ONE);
    read_expect("R5 write after unlock", 0, 6'd2, 16'h2222);
  endtask

  task automatic t_abort;
    logic o;
    head(2'b01, 6'd4, o);
    for (int i = 0; i < 8; i++) tick(1'b1, i[0], o);
    idle(40);
    read_expect("R8 aborted write in data", 0, 6'd4, 16'h0F0F);
    tick(1'b1, 1'b1, o); tick(1'b1, 1'b1, o); tick(1'b1, 1'b1, o);
    tick(1'b1, 1'b0, o); tick(1'b1, 1'b0, o); tick(1'b1, 1'b0, o);
    idle(40);
    read_expect("R8 aborted erase in address", 0, 6'd0, 16'h0F0F);
    read_expect("R8 read after abort", 0, 6'd2, 16'h2222);
  endtask

  task automatic t_busy_ignore;
    logic o;
    head(2'b01, 6'd9, o); data_bits(16'h1357);
    tick(1'b0, 1'b0, o);
    head(2'b11, 6'd9, o);
    idle(50);
    read_expect("R10 erase during busy ignored", 0, 6'd9, 16'h1357);
  endtask

  task automatic t_reset_relock;
    logic o;
    rst = 1'b1;
    tick(1'b0, 1'b0, o);
    tick(1'b0, 1'b0, o);
    chk("R11 sdo in mid-run reset", {31'b0, o}, 32'h0);
    rst = 1'b0;
    head(2'b01, 6'd9, o); data_bits(16'h2468); idle(30);
    read_expect("R6 reset relocks, array kept", 0, 6'd9, 16'h1357);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_erase_all();
    t_write_read();
    t_erase();
    t_write_all();
    t_lock();
    t_abort();
    t_busy_ignore();
    t_reset_relock();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule